// File: doc/BRIEF.md
# Mirror Window Address Remapper

This block sits on the data side of a processor, between the core's load/store address and a flat byte-addressed memory with a 20-bit physical space. Every incoming address is first cut down to 20 bits. A data access that falls inside a programmable window in the upper RAM area is redirected to the matching window in low code memory. A bank-select input, driven from a processor-mode control bit, moves any redirected address into the second 64 KiB code bank. A data read of byte or halfword size that lands in the window raises a registered stall request toward the bus for a fixed number of cycles. This gives the slower code array time to answer.

Instruction fetches use a separate path that never passes through the window. The fetch path only masks the address. It also flags fetches that fall in the empty gap between the end of code memory and the start of the peripheral area, so that the fetch logic returns an all-ones byte for them. The window's RAM base, code base and length are held in three registers. These registers reset to the default window and can be rewritten through a small write port.

Top module: `mirror_remap`

## Requirements
- R1: Only the low 20 bits of the data address and of the fetch address are used; the upper input bits never affect any output.
- R2: After reset the window covers data addresses 0xF1000 up to 0xF7FFF (length 0x7000) and maps them onto code addresses starting at 0x01000.
- R3: While `dreq` is high, a data address A with base <= A < base + length sets `dhit` and drives `dpaddr` = A - base + codebase (20 bits). Any other address drives `dpaddr` = A with `dhit` low. `dhit` is always low when `dreq` is low.
- R4: When `bank_sel` is 1, bit 16 of a redirected address is forced to 1. Addresses outside the window are unaffected.
- R5: A data read (`dwr`=0) that hits the window with `dsize` byte (0) or halfword (1) raises `stall` for exactly 3 cycles, starting in the cycle after the access. Word reads (`dsize`=2), writes and misses never raise `stall`.
- R6: `fpaddr` equals the masked fetch address, even when that address lies inside the window.
- R7: `fblank` is high exactly when the masked fetch address is at or above the code limit (default 0x40000) and below 0xF0000.
- R8: A write with `cfg_we` loads `cfg_wdata` into the register chosen by `cfg_sel` (0 = RAM base, 1 = code base, 2 = length; 3 writes nothing). The new value takes effect from the next cycle; an access in the same cycle as the write still uses the old window.
- R9: A length of zero disables the window, so no address hits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration register select |
| cfg_wdata | input | 20 | Configuration write value |
| bank_sel | input | 1 | Selects the upper 64 KiB code bank for redirected addresses |
| dreq | input | 1 | Data access valid |
| dwr | input | 1 | Data access is a write |
| dsize | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| daddr | input | 24 | Data address from the core |
| dpaddr | output | 20 | Physical data address |
| dhit | output | 1 | Data access falls in the mirror window |
| stall | output | 1 | Registered wait request to the bus |
| faddr | input | 24 | Fetch address from the core |
| fpaddr | output | 20 | Physical fetch address |
| fblank | output | 1 | Fetch lies in the unpopulated gap; return 0xFF |

## Verification
Two functions can act in the same cycle. A configuration write can coincide with a data access into the window, and a fetch and a data access can present the same window address. The bench drives a configuration write together with a data access and checks that the access is translated with the old window in that cycle and with the new window in the next one. It also drives one window address on both the fetch and data paths at once, then checks that only the data path is redirected and stalled.

// File: rtl/remap_pkg.sv
package remap_pkg;
  localparam int unsigned PA_W = 20;

  localparam logic [PA_W-1:0] DEF_RAM_BASE  = 20'hF1000;
  localparam logic [PA_W-1:0] DEF_CODE_BASE = 20'h01000;
  localparam logic [PA_W-1:0] DEF_WIN_LEN   = 20'h07000;

  typedef enum logic [1:0] {
    CFG_RAM_BASE  = 2'd0,
    CFG_CODE_BASE = 2'd1,
    CFG_WIN_LEN   = 2'd2,
    CFG_NONE      = 2'd3
  } cfg_sel_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  typedef struct packed {
    logic [PA_W-1:0] ram_base;
    logic [PA_W-1:0] code_base;
    logic [PA_W-1:0] win_len;
  } win_cfg_t;
endpackage

// File: rtl/remap_cfg.sv
module remap_cfg
  import remap_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [1:0]      sel,
  input  logic [PA_W-1:0] wdata,
  output win_cfg_t        cfg
);
  win_cfg_t cfg_q, cfg_d;
  logic     upd_en;

  assign upd_en = we && (sel != CFG_NONE);

  always_comb begin
    cfg_d = cfg_q;
    unique case (sel)
      CFG_RAM_BASE:  cfg_d.ram_base  = wdata;
      CFG_CODE_BASE: cfg_d.code_base = wdata;
      CFG_WIN_LEN:   cfg_d.win_len   = wdata;
      default:       cfg_d = cfg_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q.ram_base  <= DEF_RAM_BASE;
      cfg_q.code_base <= DEF_CODE_BASE;
      cfg_q.win_len   <= DEF_WIN_LEN;
    end else if (upd_en) begin
      cfg_q <= cfg_d;
    end
  end

  assign cfg = cfg_q;

  AST_LEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(cfg_q.win_len)); // R8
  AST_NONE_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (we && sel == CFG_NONE) |=> $stable(cfg_q)); // R8
endmodule

// File: rtl/remap_window.sv
module remap_window
  import remap_pkg::*;
#(
  parameter int unsigned IN_W     = 24,
  parameter int unsigned BANK_BIT = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  win_cfg_t        cfg,
  input  logic            bank_sel,
  input  logic            req,
  input  logic [IN_W-1:0] addr,
  output logic [PA_W-1:0] paddr,
  output logic            hit
);
  localparam int unsigned EXT_W = PA_W + 1;

  logic [PA_W-1:0]      a_m;
  logic [IN_W-PA_W-1:0] addr_hi_unused;
  logic [EXT_W-1:0]     a_ext, lo_ext, hi_ext;
  logic                 in_win;
  logic [PA_W-1:0]      offs, redir;

  assign a_m            = addr[PA_W-1:0];
  assign addr_hi_unused = addr[IN_W-1:PA_W];

  always_comb begin
    a_ext  = {1'b0, a_m};
    lo_ext = {1'b0, cfg.ram_base};
    hi_ext = lo_ext + {1'b0, cfg.win_len};
    in_win = (a_ext >= lo_ext) && (a_ext < hi_ext);
    offs   = a_m - cfg.ram_base;
    redir  = offs + cfg.code_base;
    if (bank_sel) redir[BANK_BIT] = 1'b1;
  end

  assign hit   = req && in_win;
  assign paddr = in_win ? redir : a_m;

  AST_BANK_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && bank_sel) |-> paddr[BANK_BIT]); // R4
  AST_MISS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !hit) |-> (paddr == addr[PA_W-1:0])); // R3
  AST_ZERO_LEN_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.win_len == '0) |-> !hit); // R9
endmodule

// File: rtl/remap_fetch.sv
module remap_fetch
  import remap_pkg::*;
#(
  parameter int unsigned           IN_W       = 24,
  parameter logic [PA_W:0]         CODE_LIMIT = 21'h040000,
  parameter logic [PA_W-1:0]       SFR_START  = 20'hF0000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [IN_W-1:0] addr,
  output logic [PA_W-1:0] paddr,
  output logic            blank
);
  logic [IN_W-PA_W-1:0] fhi_unused;
  logic [PA_W-1:0]      f_m;

  assign f_m        = addr[PA_W-1:0];
  assign fhi_unused = addr[IN_W-1:PA_W];
  assign paddr      = f_m;
  assign blank      = ({1'b0, f_m} >= CODE_LIMIT) && (f_m < SFR_START);

  AST_BLANK_BELOW_SFR: assert property (@(posedge clk) disable iff (!rst_n)
    blank |-> (paddr < SFR_START)); // R7
endmodule

// File: rtl/remap_wait.sv
module remap_wait
  import remap_pkg::*;
#(
  parameter int unsigned WAIT_CYC = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hit,
  input  logic       wr,
  input  logic [1:0] size,
  output logic       stall
);
  localparam int unsigned WAIT_W = $clog2(WAIT_CYC + 1);
  localparam logic [WAIT_W-1:0] WAIT_LD = WAIT_W'(WAIT_CYC);

  logic [WAIT_W-1:0] cnt_q, cnt_d;
  logic              slow_rd, busy, cnt_en;

  assign slow_rd = hit && !wr && ((size == SZ_BYTE) || (size == SZ_HALF));
  assign busy    = (cnt_q != '0);
  assign cnt_en  = slow_rd || busy;

  always_comb begin
    cnt_d = cnt_q;
    if (busy)         cnt_d = cnt_q - 1'b1;
    else if (slow_rd) cnt_d = WAIT_LD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (cnt_en)  cnt_q <= cnt_d;
  end

  assign stall = busy;

  AST_STALL_START: assert property (@(posedge clk) disable iff (!rst_n)
    (slow_rd && !stall) |=> stall); // R5
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    (!slow_rd && !stall) |=> !stall); // R5
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= WAIT_LD); // R5
endmodule

// File: rtl/mirror_remap.sv
module mirror_remap
  import remap_pkg::*;
#(
  parameter int unsigned     IN_W       = 24,
  parameter int unsigned     BANK_BIT   = 16,
  parameter int unsigned     WAIT_CYC   = 3,
  parameter logic [PA_W:0]   CODE_LIMIT = 21'h040000,
  parameter logic [PA_W-1:0] SFR_START  = 20'hF0000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [1:0]      cfg_sel,
  input  logic [19:0]     cfg_wdata,
  input  logic            bank_sel,
  input  logic            dreq,
  input  logic            dwr,
  input  logic [1:0]      dsize,
  input  logic [23:0]     daddr,
  output logic [19:0]     dpaddr,
  output logic            dhit,
  output logic            stall,
  input  logic [23:0]     faddr,
  output logic [19:0]     fpaddr,
  output logic            fblank
);
  win_cfg_t cfg;

  remap_cfg u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .sel   (cfg_sel),
    .wdata (cfg_wdata),
    .cfg   (cfg)
  );

  remap_window #(.IN_W(IN_W), .BANK_BIT(BANK_BIT)) u_win (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg      (cfg),
    .bank_sel (bank_sel),
    .req      (dreq),
    .addr     (daddr),
    .paddr    (dpaddr),
    .hit      (dhit)
  );

  remap_wait #(.WAIT_CYC(WAIT_CYC)) u_wait (
    .clk   (clk),
    .rst_n (rst_n),
    .hit   (dhit),
    .wr    (dwr),
    .size  (dsize),
    .stall (stall)
  );

  remap_fetch #(.IN_W(IN_W), .CODE_LIMIT(CODE_LIMIT), .SFR_START(SFR_START)) u_fetch (
    .clk   (clk),
    .rst_n (rst_n),
    .addr  (faddr),
    .paddr (fpaddr),
    .blank (fblank)
  );

  AST_FETCH_NEVER_REDIR: assert property (@(posedge clk) disable iff (!rst_n)
    (fpaddr == faddr[19:0])); // R6
  AST_IDLE_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    !dreq |-> !dhit); // R3
endmodule

// File: tb/sim_mirror_remap.sv
module sim_mirror_remap;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [1:0]  cfg_sel;
  logic [19:0] cfg_wdata;
  logic        bank_sel;
  logic        dreq, dwr;
  logic [1:0]  dsize;
  logic [23:0] daddr, faddr;
  logic [19:0] dpaddr, fpaddr;
  logic        dhit, stall, fblank;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mirror_remap u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .bank_sel(bank_sel), .dreq(dreq), .dwr(dwr),
    .dsize(dsize), .daddr(daddr), .dpaddr(dpaddr), .dhit(dhit),
    .stall(stall), .faddr(faddr), .fpaddr(fpaddr), .fblank(fblank)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    cfg_we = 0; cfg_sel = 0; cfg_wdata = 0; dreq = 0; dwr = 0;
    dsize = 0; daddr = 0; faddr = 0;
  endtask

  task automatic cfg_write(input logic [1:0] s, input logic [19:0] v);
    @(negedge clk);
    cfg_we = 1; cfg_sel = s; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic probe(input logic [23:0] a, input logic [19:0] exp_pa,
                       input logic exp_hit, input string tag);
    @(negedge clk);
    dreq = 1; dwr = 1; dsize = 2; daddr = a;
    #1;
    check({tag, " paddr"}, 32'(dpaddr), 32'(exp_pa));
    check({tag, " hit"}, 32'(dhit), 32'(exp_hit));
    @(negedge clk);
    dreq = 0;
  endtask

  task automatic test_reset();
    check("R2 stall after reset", 32'(stall), 0);
    check("R3 no hit when idle", 32'(dhit), 0);
  endtask

  task automatic test_default_window();
    probe(24'h0F1000, 20'h01000, 1, "R2 base");
    probe(24'h0F7FFF, 20'h07FFF, 1, "R2 last");
    probe(24'h0F8000, 20'hF8000, 0, "R3 above end");
    probe(24'h0F0FFF, 20'hF0FFF, 0, "R3 below base");
    probe(24'h5F1234, 20'h01234, 1, "R1 masked hit");
    probe(24'hAF8000, 20'hF8000, 0, "R1 masked miss");
    @(negedge clk);
    dreq = 0; daddr = 24'h0F2000; #1;
    check("R3 hit needs dreq", 32'(dhit), 0);
  endtask

  task automatic test_bank();
    bank_sel = 1;
    probe(24'h0F1000, 20'h11000, 1, "R4 bank redirect");
    probe(24'h0F9000, 20'hF9000, 0, "R4 bank outside");
    bank_sel = 0;
  endtask

  task automatic stall_run(input logic wr, input logic [1:0] sz,
                           input logic [23:0] a, input int exp_cycles, input string tag);
    @(negedge clk);
    dreq = 1; dwr = wr; dsize = sz; daddr = a;
    @(negedge clk);
    dreq = 0;
    for (int i = 0; i < 4; i++) begin
      check($sformatf("%s cycle %0d", tag, i), 32'(stall), (i < exp_cycles) ? 1 : 0);
      @(negedge clk);
    end
  endtask

  task automatic test_stall();
    stall_run(0, 0, 24'h0F1010, 3, "R5 byte read");
    stall_run(0, 1, 24'h0F1010, 3, "R5 half read");
    stall_run(0, 2, 24'h0F1010, 0, "R5 word read");
    stall_run(1, 0, 24'h0F1010, 0, "R5 byte write");
    stall_run(0, 0, 24'h0F9010, 0, "R5 byte miss");
  endtask

  task automatic test_fetch();
    @(negedge clk);
    faddr = 24'h0F1000; dreq = 1; dwr = 0; dsize = 0; daddr = 24'h0F1000; #1;
    check("R6 fetch not redirected", 32'(fpaddr), 32'h0F1000);
    check("R6 data redirected same cycle", 32'(dpaddr), 32'h01000);
    @(negedge clk);
    dreq = 0;
    check("R6 data stall same cycle", 32'(stall), 1);
    faddr = 24'h33FFFF; #1;
    check("R1 fetch masked", 32'(fpaddr), 32'h3FFFF);
    check("R7 below limit", 32'(fblank), 0);
    faddr = 24'h040000; #1;
    check("R7 at limit", 32'(fblank), 1);
    faddr = 24'h0EFFFF; #1;
    check("R7 top of gap", 32'(fblank), 1);
    faddr = 24'hAF0000; #1;
    check("R7 sfr start", 32'(fblank), 0);
    repeat (3) @(negedge clk);
  endtask

  task automatic test_config();
    @(negedge clk);
    cfg_we = 1; cfg_sel = 0; cfg_wdata = 20'hE0000;
    dreq = 1; dwr = 1; dsize = 2; daddr = 24'h0F1000; #1;
    check("R8 old window same cycle", 32'(dpaddr), 32'h01000);
    @(negedge clk);
    cfg_we = 0; #1;
    check("R8 new base next cycle", 32'(dhit), 0);
    dreq = 0;
    cfg_write(1, 20'h20000);
    cfg_write(2, 20'h00100);
    probe(24'h0E0010, 20'h20010, 1, "R8 new map");
    probe(24'h0E0100, 20'hE0100, 0, "R8 new end");
    bank_sel = 1;
    probe(24'h0E0010, 20'h30010, 1, "R4 bank new map");
    bank_sel = 0;
    cfg_write(3, 20'h00000);
    probe(24'h0E00FF, 20'h200FF, 1, "R8 sel3 ignored");
    cfg_write(2, 20'h00000);
    probe(24'h0E0000, 20'hE0000, 0, "R9 zero length");
  endtask

  initial begin
    idle(); bank_sel = 0; rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    test_reset();
    test_default_window();
    test_bank();
    test_stall();
    test_fetch();
    test_config();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule